// File: doc/BRIEF.md
# Single-Bit Host Command Port for a Display Sequencer

This block is the host-facing control port of a display sequencer. The host places a 4-bit command address and one data bit on the port, then returns a write strobe from low to high. That rising edge runs one command. A command can shift the data bit into a control word, issue a one-cycle pulse to a neighbouring block (state RAM write, RAM address step, sequence reset, master reset, gate-flag clear), set a latched mode or slope level, or place a force on the B trigger source, B slope, delay-select, blanking and holdoff outputs. The last write at a reserved address cancels the B forces.

While the host holds the read strobe low, the port drives one status bit chosen by the address: the control word's most significant bit, the RAM comparator result, the end-of-single-sequence flag, the end-of-sequence signal, or one of the two gate-detect flags. Both strobes are synchronised into the system clock domain and their edges are detected there. The bidirectional data pin is presented as separate input, output and output-enable signals, so that the pad can be placed outside the block.

Top module: `dseq_host_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control word, load_mode, a_slope and every force latch are 0. No pulse output is high and dio_oe is 0.
- R2: A write at address 0x0 shifts dio_i into bit 0 of ctrl_word and moves the older bits up by one position.
- R3: Addresses 0x1, 0x2, 0x3, 0x4 and 0x6 each produce exactly one single-cycle pulse, on ram_wr_p, addr_step_p, seq_reset_p, master_reset_p and gate_clr_p respectively. No other write produces a pulse.
- R4: A write at 0x5 sets load_mode to dio_i.
- R5: A write at 0x7 sets a_slope to dio_i.
- R6: A write at 0x8 starts the B1/B2 force. While it is active, b_src, b_slope and ds all equal the written bit (1 selects B1). When it is not active, they follow norm_b_src, norm_b_slope and norm_ds.
- R7: A write at 0x9 starts a B-slope force. While it is active, b_slope equals that write's bit, whatever the state of the B1/B2 force.
- R8: A write at 0xE, with any data bit, ends both the B1/B2 force and the B-slope force.
- R9: A write at 0xA or 0xB with dio_i=1 holds blank or tho high. With dio_i=0, that output follows norm_blank or norm_tho again.
- R10: While rd_n is low, dio_o carries the status bit for the address. 0x0 gives ctrl_word msb, 0x1 gives stat_ram_match, 0x2 gives stat_eoss and 0x3 gives stat_eos. Even addresses in 0x4-0x7 give stat_gate_a and odd ones give stat_gate_b. Any address at 0x8 or above gives 0.
- R11: dio_oe is 1 only while the synchronised rd_n is low.
- R12: Writes at 0xC, 0xD and 0xF change no output.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Command / status address |
| wr_strobe | input | 1 | Write strobe; idle high, a command runs on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| dio_i | input | 1 | Data bit from the pad |
| dio_o | output | 1 | Status bit to the pad |
| dio_oe | output | 1 | Pad output enable |
| stat_ram_match | input | 1 | RAM comparator result |
| stat_eoss | input | 1 | End-of-single-sequence flag |
| stat_eos | input | 1 | End-of-sequence signal |
| stat_gate_a | input | 1 | A gate-detect flag |
| stat_gate_b | input | 1 | B gate-detect flag |
| norm_b_src | input | 1 | Unforced B trigger source |
| norm_b_slope | input | 1 | Unforced B slope |
| norm_ds | input | 1 | Unforced delay select |
| norm_blank | input | 1 | Unforced blanking level |
| norm_tho | input | 1 | Unforced holdoff level |
| ctrl_word | output | CTRL_W | Control word |
| load_mode | output | 1 | RAM load mode |
| a_slope | output | 1 | A trigger slope |
| ram_wr_p | output | 1 | State RAM write pulse |
| addr_step_p | output | 1 | RAM address step pulse |
| seq_reset_p | output | 1 | Sequence / holdoff reset pulse |
| master_reset_p | output | 1 | Master reset pulse |
| gate_clr_p | output | 1 | Gate-flag clear pulse |
| b_src | output | 1 | B trigger source (1 = B1) |
| b_slope | output | 1 | B slope |
| ds | output | 1 | Delay select |
| blank | output | 1 | Blanking |
| tho | output | 1 | Holdoff output |

## Verification
A write and a read can overlap. The host can hold rd_n low at address 0x0 while it strobes a write to the same address, so the status bit being driven is also the bit that the shift changes. The bench provokes this by keeping the read active across the write. It then checks that dio_o shows the new msb, computed from its own shift model, once the write has settled. The two forces can also be active at once. After 0x8 and then 0x9 with opposite data bits, b_slope must show the B-slope force while b_src and ds still show the B1/B2 force.

// File: rtl/dseq_cmd_pkg.sv
// Shared command codes and the decoded-command record for the host port.
// Assumes a 4-bit command address; codes 0xC, 0xD and 0xF are unused.
package dseq_cmd_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        CMD_CTRL     = 4'h0,
        CMD_RAM_WR   = 4'h1,
        CMD_ADDR_INC = 4'h2,
        CMD_SEQ_RST  = 4'h3,
        CMD_MST_RST  = 4'h4,
        CMD_LOAD     = 4'h5,
        CMD_GATE_CLR = 4'h6,
        CMD_A_SLOPE  = 4'h7,
        CMD_B12      = 4'h8,
        CMD_BSLOPE   = 4'h9,
        CMD_BLANK    = 4'hA,
        CMD_THO      = 4'hB,
        CMD_CANCEL   = 4'hE
    } cmd_e;

    typedef struct packed {
        logic ctrl_shift;
        logic ram_wr;
        logic addr_inc;
        logic seq_rst;
        logic mst_rst;
        logic load;
        logic gate_clr;
        logic a_slope;
        logic b12;
        logic bslope;
        logic blank;
        logic tho;
        logic cancel;
    } cmd_hits_t;

endpackage

// File: rtl/strobe_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous strobe lines.
// Assumes that each line is idle high, so the reset value holds each stage high
// and no false edge can appear when reset is released.
module strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Chain of flops per line; stage 0 takes the pin, the last stage is the output.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cmd_decode.sv
// Detects the rising edge of the synchronised write strobe and turns the
// address into a one-hot, single-cycle command record. The data bit is captured
// with it. Assumes that the host holds the address and data stable while the
// strobe passes through the synchroniser.
module cmd_decode
    import dseq_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_level,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_in,
    output cmd_hits_t         hits,
    output logic              data_q
);

    logic      wr_prev;
    logic      fire;
    cmd_hits_t hits_d;

    assign fire = wr_level & ~wr_prev;

    // Map the address to one command flag, only on a strobe rising edge.
    always_comb begin
        hits_d = '0;
        if (fire) begin
            case (addr)
                CMD_CTRL:     hits_d.ctrl_shift = 1'b1;
                CMD_RAM_WR:   hits_d.ram_wr     = 1'b1;
                CMD_ADDR_INC: hits_d.addr_inc   = 1'b1;
                CMD_SEQ_RST:  hits_d.seq_rst    = 1'b1;
                CMD_MST_RST:  hits_d.mst_rst    = 1'b1;
                CMD_LOAD:     hits_d.load       = 1'b1;
                CMD_GATE_CLR: hits_d.gate_clr   = 1'b1;
                CMD_A_SLOPE:  hits_d.a_slope    = 1'b1;
                CMD_B12:      hits_d.b12        = 1'b1;
                CMD_BSLOPE:   hits_d.bslope     = 1'b1;
                CMD_BLANK:    hits_d.blank      = 1'b1;
                CMD_THO:      hits_d.tho        = 1'b1;
                CMD_CANCEL:   hits_d.cancel     = 1'b1;
                default:      hits_d = '0;
            endcase
        end
    end

    // Register the edge history, the command record and the data captured with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
            hits    <= '0;
            data_q  <= 1'b0;
        end else begin
            wr_prev <= wr_level;
            hits    <= hits_d;
            if (fire) data_q <= data_in;
        end
    end

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits)) else $error("more than one command flag");          // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> (hits == '0)) else $error("command held two cycles"); // R3

endmodule

// File: rtl/force_outputs.sv
// Force latches for the B trigger source, B slope, delay-select, blanking and
// holdoff outputs, together with their precedence muxes. The B-slope force wins
// over the B1/B2 force. A cancel command ends both B forces. Assumes that at
// most one command flag is high in any cycle.
module force_outputs (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_b12,
    input  logic hit_bslope,
    input  logic hit_blank,
    input  logic hit_tho,
    input  logic hit_cancel,
    input  logic data,
    input  logic norm_b_src,
    input  logic norm_b_slope,
    input  logic norm_ds,
    input  logic norm_blank,
    input  logic norm_tho,
    output logic b_src,
    output logic b_slope,
    output logic ds,
    output logic blank,
    output logic tho
);

    logic b12_on, b12_sel;
    logic bs_on, bs_val;
    logic blank_on, tho_on;

    // Latch the force state carried by each force or cancel command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b12_on   <= 1'b0;
            b12_sel  <= 1'b0;
            bs_on    <= 1'b0;
            bs_val   <= 1'b0;
            blank_on <= 1'b0;
            tho_on   <= 1'b0;
        end else begin
            if (hit_b12) begin
                b12_on  <= 1'b1;
                b12_sel <= data;
            end
            if (hit_bslope) begin
                bs_on  <= 1'b1;
                bs_val <= data;
            end
            if (hit_cancel) begin
                b12_on <= 1'b0;
                bs_on  <= 1'b0;
            end
            if (hit_blank) blank_on <= data;
            if (hit_tho)   tho_on   <= data;
        end
    end

    // Output selection in priority order: B-slope force, then B1/B2 force, then the normal level.
    always_comb begin
        b_src   = b12_on ? b12_sel : norm_b_src;
        ds      = b12_on ? b12_sel : norm_ds;
        b_slope = bs_on ? bs_val : (b12_on ? b12_sel : norm_b_slope);
        blank   = blank_on | norm_blank;
        tho     = tho_on | norm_tho;
    end

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cancel |=> (!b12_on && !bs_on)) else $error("cancel left a force"); // R8
    AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_b12 || hit_bslope || hit_cancel) |=> $stable({b12_on, b12_sel, bs_on, bs_val}))
        else $error("B force changed without a command");                     // R6

endmodule

// File: rtl/dseq_host_port.sv
// Host command port for the display sequencer. It synchronises the write and
// read strobes and decodes the single-bit commands. It holds the control word,
// the load-mode and A-slope latches and the forced outputs, and it drives the
// status bit selected by the address while a read is active. Assumes that the
// address and data are stable around each strobe.
module dseq_host_port
    import dseq_cmd_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              wr_strobe,
    input  logic              rd_n,
    input  logic              dio_i,
    output logic              dio_o,
    output logic              dio_oe,
    input  logic              stat_ram_match,
    input  logic              stat_eoss,
    input  logic              stat_eos,
    input  logic              stat_gate_a,
    input  logic              stat_gate_b,
    input  logic              norm_b_src,
    input  logic              norm_b_slope,
    input  logic              norm_ds,
    input  logic              norm_blank,
    input  logic              norm_tho,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic              load_mode,
    output logic              a_slope,
    output logic              ram_wr_p,
    output logic              addr_step_p,
    output logic              seq_reset_p,
    output logic              master_reset_p,
    output logic              gate_clr_p,
    output logic              b_src,
    output logic              b_slope,
    output logic              ds,
    output logic              blank,
    output logic              tho
);

    localparam int MSB = CTRL_W - 1;

    logic [1:0] strobes_s;
    logic       wr_level, rd_level;
    cmd_hits_t  hits;
    logic       cmd_data;
    logic       status_bit;

    strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rd_n, wr_strobe}),
        .sync_out (strobes_s)
    );
    assign wr_level = strobes_s[0];
    assign rd_level = strobes_s[1];

    cmd_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_level (wr_level),
        .addr     (host_addr),
        .data_in  (dio_i),
        .hits     (hits),
        .data_q   (cmd_data)
    );

    force_outputs u_force (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_b12      (hits.b12),
        .hit_bslope   (hits.bslope),
        .hit_blank    (hits.blank),
        .hit_tho      (hits.tho),
        .hit_cancel   (hits.cancel),
        .data         (cmd_data),
        .norm_b_src   (norm_b_src),
        .norm_b_slope (norm_b_slope),
        .norm_ds      (norm_ds),
        .norm_blank   (norm_blank),
        .norm_tho     (norm_tho),
        .b_src        (b_src),
        .b_slope      (b_slope),
        .ds           (ds),
        .blank        (blank),
        .tho          (tho)
    );

    // Single-cycle pulses to the neighbouring blocks.
    assign ram_wr_p       = hits.ram_wr;
    assign addr_step_p    = hits.addr_inc;
    assign seq_reset_p    = hits.seq_rst;
    assign master_reset_p = hits.mst_rst;
    assign gate_clr_p     = hits.gate_clr;

    // Control word shift and the two plain level latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word <= '0;
            load_mode <= 1'b0;
            a_slope   <= 1'b0;
        end else begin
            if (hits.ctrl_shift) ctrl_word <= {ctrl_word[MSB-1:0], cmd_data};
            if (hits.load)       load_mode <= cmd_data;
            if (hits.a_slope)    a_slope   <= cmd_data;
        end
    end

    // Status selection by address: low quarter direct, second quarter gate flags.
    always_comb begin
        status_bit = 1'b0;
        if (host_addr[3:2] == 2'b00) begin
            case (host_addr[1:0])
                2'd0:    status_bit = ctrl_word[MSB];
                2'd1:    status_bit = stat_ram_match;
                2'd2:    status_bit = stat_eoss;
                default: status_bit = stat_eos;
            endcase
        end else if (host_addr[3:2] == 2'b01) begin
            status_bit = host_addr[0] ? stat_gate_b : stat_gate_a;
        end
    end

    // Registered read path; the pad is released whenever the read strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dio_o  <= 1'b0;
            dio_oe <= 1'b0;
        end else begin
            dio_o  <= status_bit;
            dio_oe <= ~rd_level;
        end
    end

    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level |=> !dio_oe) else $error("pad driven with read idle");          // R11
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hits.ctrl_shift |=> $stable(ctrl_word)) else $error("ctrl word moved"); // R2
    AST_LEVELS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hits.load || hits.a_slope) |=> $stable({load_mode, a_slope}))
        else $error("level latch moved");                                        // R12

endmodule

// File: tb/dseq_host_port_test.sv
module dseq_host_port_test;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    host_addr = 4'h0;
    logic          wr_strobe = 1'b1;
    logic          rd_n = 1'b1;
    logic          dio_i = 1'b0;
    logic          dio_o, dio_oe;
    logic          st_match = 1'b0, st_eoss = 1'b0, st_eos = 1'b0, st_ga = 1'b0, st_gb = 1'b0;
    logic          n_src = 1'b0, n_slope = 1'b0, n_ds = 1'b0, n_blank = 1'b0, n_tho = 1'b0;
    logic [CW-1:0] ctrl_word;
    logic          load_mode, a_slope;
    logic          ram_wr_p, addr_step_p, seq_reset_p, master_reset_p, gate_clr_p;
    logic          b_src, b_slope, ds, blank, tho;

    int checks = 0;
    int errors = 0;
    int pcnt [5];
    int ecnt [5];

    logic [CW-1:0] m_ctrl;
    logic m_load, m_aslope, m_b12_on, m_b12_sel, m_bs_on, m_bs_val, m_blank, m_tho;

    always #5 clk = ~clk;

    dseq_host_port #(.CTRL_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .wr_strobe(wr_strobe), .rd_n(rd_n),
        .dio_i(dio_i), .dio_o(dio_o), .dio_oe(dio_oe),
        .stat_ram_match(st_match), .stat_eoss(st_eoss), .stat_eos(st_eos),
        .stat_gate_a(st_ga), .stat_gate_b(st_gb),
        .norm_b_src(n_src), .norm_b_slope(n_slope), .norm_ds(n_ds),
        .norm_blank(n_blank), .norm_tho(n_tho),
        .ctrl_word(ctrl_word), .load_mode(load_mode), .a_slope(a_slope),
        .ram_wr_p(ram_wr_p), .addr_step_p(addr_step_p), .seq_reset_p(seq_reset_p),
        .master_reset_p(master_reset_p), .gate_clr_p(gate_clr_p),
        .b_src(b_src), .b_slope(b_slope), .ds(ds), .blank(blank), .tho(tho)
    );

    // Pulse counters observed at the ports.
    always @(posedge clk) begin
        if (rst_n) begin
            if (ram_wr_p)       pcnt[0] <= pcnt[0] + 1;
            if (addr_step_p)    pcnt[1] <= pcnt[1] + 1;
            if (seq_reset_p)    pcnt[2] <= pcnt[2] + 1;
            if (master_reset_p) pcnt[3] <= pcnt[3] + 1;
            if (gate_clr_p)     pcnt[4] <= pcnt[4] + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic d);
        @(negedge clk);
        host_addr = a;
        dio_i     = d;
        @(negedge clk);
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b1;
        repeat (6) @(negedge clk);
        case (a)
            4'h0: m_ctrl = {m_ctrl[CW-2:0], d};
            4'h1: ecnt[0]++;
            4'h2: ecnt[1]++;
            4'h3: ecnt[2]++;
            4'h4: ecnt[3]++;
            4'h5: m_load = d;
            4'h6: ecnt[4]++;
            4'h7: m_aslope = d;
            4'h8: begin m_b12_on = 1'b1; m_b12_sel = d; end
            4'h9: begin m_bs_on = 1'b1; m_bs_val = d; end
            4'hA: m_blank = d;
            4'hB: m_tho = d;
            4'hE: begin m_b12_on = 1'b0; m_bs_on = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic check_outputs(input string tag);
        logic e_slope;
        e_slope = m_bs_on ? m_bs_val : (m_b12_on ? m_b12_sel : n_slope);
        chk({tag, " R2 ctrl_word"}, int'(ctrl_word), int'(m_ctrl));
        chk({tag, " R4 load_mode"}, int'(load_mode), int'(m_load));
        chk({tag, " R5 a_slope"}, int'(a_slope), int'(m_aslope));
        chk({tag, " R3 ram_wr_p count"}, pcnt[0], ecnt[0]);
        chk({tag, " R3 addr_step_p count"}, pcnt[1], ecnt[1]);
        chk({tag, " R3 seq_reset_p count"}, pcnt[2], ecnt[2]);
        chk({tag, " R3 master_reset_p count"}, pcnt[3], ecnt[3]);
        chk({tag, " R3 gate_clr_p count"}, pcnt[4], ecnt[4]);
        chk({tag, " R6 b_src"}, int'(b_src), int'(m_b12_on ? m_b12_sel : n_src));
        chk({tag, " R6 ds"}, int'(ds), int'(m_b12_on ? m_b12_sel : n_ds));
        chk({tag, " R7 b_slope"}, int'(b_slope), int'(e_slope));
        chk({tag, " R9 blank"}, int'(blank), int'(m_blank | n_blank));
        chk({tag, " R9 tho"}, int'(tho), int'(m_tho | n_tho));
    endtask

    function automatic logic exp_status(input logic [3:0] a);
        if (a[3:2] == 2'b00) begin
            case (a[1:0])
                2'd0:    return m_ctrl[CW-1];
                2'd1:    return st_match;
                2'd2:    return st_eoss;
                default: return st_eos;
            endcase
        end else if (a[3:2] == 2'b01) begin
            return a[0] ? st_gb : st_ga;
        end
        return 1'b0;
    endfunction

    initial begin
        for (int i = 0; i < 5; i++) begin pcnt[i] = 0; ecnt[i] = 0; end
        m_ctrl = '0; m_load = 0; m_aslope = 0; m_b12_on = 0; m_b12_sel = 0;
        m_bs_on = 0; m_bs_val = 0; m_blank = 0; m_tho = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check_outputs("R1 reset");
        chk("R1 dio_oe after reset", int'(dio_oe), 0);

        // Sweep every address and data bit with changing normal levels (R2-R9, R12).
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 16; a++) begin
                for (int d = 0; d < 2; d++) begin
                    {n_src, n_slope, n_ds, n_blank, n_tho} = 5'((a * 7 + d * 3 + p * 11) % 32);
                    do_write(4'(a), 1'(d));
                    check_outputs((a >= 12 && a != 14) ? "R12 unused" : "R3-R9 sweep");
                end
            end
        end

        // Both forces active with opposite bits: R7 precedence, R6 still on source/ds.
        n_src = 1'b0; n_slope = 1'b0; n_ds = 1'b0;
        do_write(4'h8, 1'b1);
        do_write(4'h9, 1'b0);
        check_outputs("R7 precedence");
        chk("R7 b_slope forced low", int'(b_slope), 0);
        chk("R6 b_src forced B1", int'(b_src), 1);
        do_write(4'hE, 1'b1);
        n_src = 1'b1; n_slope = 1'b1; n_ds = 1'b0;
        repeat (2) @(negedge clk);
        check_outputs("R8 after cancel");

        // Read sweep over every address and status pattern (R10, R11).
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 32; s++) begin
                {st_match, st_eoss, st_eos, st_ga, st_gb} = 5'(s);
                host_addr = 4'(a);
                rd_n = 1'b0;
                repeat (5) @(negedge clk);
                chk("R11 dio_oe during read", int'(dio_oe), 1);
                chk("R10 status bit", int'(dio_o), int'(exp_status(4'(a))));
                rd_n = 1'b1;
                repeat (5) @(negedge clk);
                chk("R11 dio_oe after read", int'(dio_oe), 0);
            end
        end

        // Overlap: write the control word while it is being read at the same address.
        for (int d = 0; d < 2; d++) begin
            host_addr = 4'h0;
            rd_n = 1'b0;
            for (int k = 0; k < CW; k++) do_write(4'h0, 1'(d ^ (k & 1)));
            chk("R10 msb after overlapped writes", int'(dio_o), int'(m_ctrl[CW-1]));
            chk("R2 ctrl_word after overlap", int'(ctrl_word), int'(m_ctrl));
            chk("R11 dio_oe held in overlap", int'(dio_oe), 1);
            rd_n = 1'b1;
            repeat (5) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule